// File: doc/BRIEF.md
# Ping-Pong Buffer Descriptor Tracker

This block keeps the bookkeeping for one DMA channel that owns two hardware buffer descriptor slots and uses them in turn. The host enqueues a buffer by giving an address and a byte size. The tracker writes the descriptor into the slot named by its issue pointer and marks that slot ready. A done strobe for each slot stands in for the DMA engine. The host starts an acknowledge pass as an interrupt would. During that pass a small state machine retires completed slots in completion order. Each retired slot bumps a request counter.

Software servicing is decoupled from acknowledgement. Each service step consumes one outstanding request, lowers the fill level and adds the buffer to a done count. A detach request then takes a number of completed buffers away from that count. Overflow, underflow and detach errors come out as one-cycle pulses. A ready flag tells the host whether another buffer can be accepted.

The acknowledge machine has three states. In ACK_IDLE it waits and moves to ACK_CHECK on `ack_start`. ACK_CHECK looks at the slot under the completion pointer. It goes to ACK_RETIRE if that slot is done and returns to ACK_IDLE if not. ACK_RETIRE clears the slot, toggles the completion pointer, increments the request counter and goes back to ACK_CHECK.

Top module: `pingpong_bd_tracker`

## Requirements
- R1: After reset the issue pointer, completion pointer, level, request counter, service counter and done count are all 0. No slot holds a ready, done or error flag, and `ready` is 1.
- R2: Suppose `enq_valid` is high and the level is below 2. At the next edge the slot selected by the issue pointer gets its ready flag set, its address set to `enq_addr` and its length field set to `enq_size` minus 1. The issue pointer toggles and the level rises by one.
- R3: An enqueue while the level is 2 is rejected. `ovf_err` is high for one cycle, and the slots and the issue pointer keep their values. The level never exceeds 2.
- R4: A `dma_done[i]` strobe sets the done flag of slot i, whatever that slot's ready flag is.
- R5: An acknowledge pass started by `ack_start` works through the slots in order. While the slot under the completion pointer has its done flag set, the pass clears that slot's done, error and ready flags, toggles the completion pointer and increments `req_cnt`. The pass ends at the first slot under the pointer that is not done, even if the other slot is done. `ack_busy` is high while the pass runs.
- R6: A service step does nothing when `svc_cnt` equals `req_cnt`. Otherwise it increments `svc_cnt`, lowers the level by one and raises `done_cnt` by one.
- R7: A service step that finds a pending request while the level is 0 increments `svc_cnt` and pulses `unf_err`. The level and `done_cnt` stay as they were.
- R8: A detach of `det_num` buffers with `det_num` greater than `done_cnt` pulses `det_err` and leaves `done_cnt` unchanged. Otherwise `det_num` is subtracted from `done_cnt`.
- R9: `ready` is 1 exactly when the level is below 2.
- R10: A `dma_err[i]` strobe sets the error flag of slot i. Retiring the slot clears it.
- R11: An accepted enqueue and a level-lowering service step in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_addr | input | AW | Buffer address to program |
| enq_size | input | SW | Buffer size in bytes, at least 1 |
| dma_done | input | 2 | Per-slot completion strobe from the DMA engine |
| dma_err | input | 2 | Per-slot error strobe from the DMA engine |
| ack_start | input | 1 | Start an acknowledge pass |
| svc_step | input | 1 | Software service step |
| det_valid | input | 1 | Detach request strobe |
| det_num | input | DCW | Number of buffers to detach |
| slot_rdy | output | 2 | Ready flag per slot |
| slot_done | output | 2 | Done flag per slot |
| slot_err | output | 2 | Error flag per slot |
| slot_addr | output | 2*AW | Slot addresses, slot 1 in the upper half |
| slot_len | output | 2*SW | Slot length fields (size-1), slot 1 in the upper half |
| issue_idx | output | 1 | Slot the next enqueue will use |
| cmpl_idx | output | 1 | Slot the next retire will examine |
| level | output | 2 | Buffers outstanding |
| req_cnt | output | CW | Retired-slot request counter |
| svc_cnt | output | CW | Service counter |
| done_cnt | output | DCW | Completed buffers not yet detached |
| ready | output | 1 | Another enqueue is allowed |
| ack_busy | output | 1 | Acknowledge pass in progress |
| ovf_err | output | 1 | Overflow pulse |
| unf_err | output | 1 | Service underflow pulse |
| det_err | output | 1 | Detach underflow pulse |

## Verification
The acknowledge pass gets three completion patterns. In the first, both slots are done at once, which shows that a single pass absorbs several completions. In the second, only the slot that is not under the completion pointer is done, which shows the pass keeps order and does not skip ahead. The third is a stray done on a slot that was never issued, which is the only way to reach the service underflow. Service steps are issued with and without a pending request, and once together with an enqueue. This separates the no-op case, the normal decrement and the net-zero level update. Detach is tried above and exactly at the done count, which places the boundary of the comparison.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_CHECK  = 2'd1,
        ACK_RETIRE = 2'd2
    } ack_state_e;

    localparam int          NUM_SLOTS = 2;
    localparam int          LVL_W     = 2;
    localparam logic [1:0]  LVL_FULL  = 2'd2;

endpackage

// File: rtl/bdt_slot.sv
module bdt_slot #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] wr_addr,
    input  logic [SW-1:0] wr_len,
    input  logic          clr,
    input  logic          hw_done,
    input  logic          hw_err,
    output logic          rdy_f,
    output logic          done_f,
    output logic          err_f,
    output logic [AW-1:0] addr_q,
    output logic [SW-1:0] len_q
);

    // Flags: retire clear wins over a new strobe in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_f  <= 1'b0;
            done_f <= 1'b0;
            err_f  <= 1'b0;
        end else if (clr) begin
            rdy_f  <= 1'b0;
            done_f <= 1'b0;
            err_f  <= 1'b0;
        end else begin
            if (wr)      rdy_f  <= 1'b1;
            if (hw_done) done_f <= 1'b1;
            if (hw_err)  err_f  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
        end else if (wr) begin
            addr_q <= wr_addr;
            len_q  <= wr_len;
        end
    end

endmodule

// File: rtl/bdt_ack_fsm.sv
module bdt_ack_fsm
    import bdt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_start,
    input  logic [1:0]    done_flags,
    output logic          cidx,
    output logic [CW-1:0] req_cnt,
    output logic          retire,
    output logic          busy
);

    ack_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:   if (ack_start) state_d = ACK_CHECK;
            ACK_CHECK:  state_d = done_flags[cidx] ? ACK_RETIRE : ACK_IDLE;
            ACK_RETIRE: state_d = ACK_CHECK;
            default:    state_d = ACK_IDLE;
        endcase
    end

    always_comb begin
        retire = (state_q == ACK_RETIRE);
        busy   = (state_q != ACK_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cidx    <= 1'b0;
            req_cnt <= '0;
        end else if (retire) begin
            cidx    <= ~cidx;
            req_cnt <= req_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bdt_acct.sv
module bdt_acct
    import bdt_pkg::*;
#(
    parameter int CW  = 8,
    parameter int DCW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             svc_step,
    input  logic [CW-1:0]    req_cnt,
    input  logic             det_valid,
    input  logic [DCW-1:0]   det_num,
    output logic             enq_ok,
    output logic             issue_idx,
    output logic [LVL_W-1:0] level,
    output logic [CW-1:0]    svc_cnt,
    output logic [DCW-1:0]   done_cnt,
    output logic             ovf_err,
    output logic             unf_err,
    output logic             det_err
);

    logic             pend, svc_take, svc_dec, svc_unf, det_ok, det_bad;
    logic [LVL_W-1:0] level_d;
    logic [DCW-1:0]   done_d;

    always_comb begin
        enq_ok   = enq_valid && (level != LVL_FULL);
        pend     = (svc_cnt != req_cnt);
        svc_take = svc_step && pend;
        svc_dec  = svc_take && (level != '0);
        svc_unf  = svc_take && (level == '0);
        det_ok   = det_valid && (det_num <= done_cnt);
        det_bad  = det_valid && !det_ok;

        unique case ({enq_ok, svc_dec})
            2'b10:   level_d = level + 1'b1;
            2'b01:   level_d = level - 1'b1;
            default: level_d = level;
        endcase

        done_d = done_cnt + {{(DCW-1){1'b0}}, svc_dec};
        if (det_ok) done_d = done_d - det_num;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_idx <= 1'b0;
            level     <= '0;
            svc_cnt   <= '0;
            done_cnt  <= '0;
            ovf_err   <= 1'b0;
            unf_err   <= 1'b0;
            det_err   <= 1'b0;
        end else begin
            if (enq_ok)   issue_idx <= ~issue_idx;
            if (svc_take) svc_cnt   <= svc_cnt + 1'b1;
            level    <= level_d;
            done_cnt <= done_d;
            ovf_err  <= enq_valid && !enq_ok;
            unf_err  <= svc_unf;
            det_err  <= det_bad;
        end
    end

endmodule

// File: rtl/pingpong_bd_tracker.sv
module pingpong_bd_tracker
    import bdt_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int CW  = 8,
    parameter int DCW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enq_valid,
    input  logic [AW-1:0]       enq_addr,
    input  logic [SW-1:0]       enq_size,
    input  logic [1:0]          dma_done,
    input  logic [1:0]          dma_err,
    input  logic                ack_start,
    input  logic                svc_step,
    input  logic                det_valid,
    input  logic [DCW-1:0]      det_num,
    output logic [1:0]          slot_rdy,
    output logic [1:0]          slot_done,
    output logic [1:0]          slot_err,
    output logic [2*AW-1:0]     slot_addr,
    output logic [2*SW-1:0]     slot_len,
    output logic                issue_idx,
    output logic                cmpl_idx,
    output logic [1:0]          level,
    output logic [CW-1:0]       req_cnt,
    output logic [CW-1:0]       svc_cnt,
    output logic [DCW-1:0]      done_cnt,
    output logic                ready,
    output logic                ack_busy,
    output logic                ovf_err,
    output logic                unf_err,
    output logic                det_err
);

    logic          enq_ok, retire;
    logic [SW-1:0] len_val;

    assign len_val = enq_size - 1'b1;
    assign ready   = (level != LVL_FULL);

    bdt_acct #(.CW(CW), .DCW(DCW)) u_acct (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .svc_step  (svc_step),
        .req_cnt   (req_cnt),
        .det_valid (det_valid),
        .det_num   (det_num),
        .enq_ok    (enq_ok),
        .issue_idx (issue_idx),
        .level     (level),
        .svc_cnt   (svc_cnt),
        .done_cnt  (done_cnt),
        .ovf_err   (ovf_err),
        .unf_err   (unf_err),
        .det_err   (det_err)
    );

    bdt_ack_fsm #(.CW(CW)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_start  (ack_start),
        .done_flags (slot_done),
        .cidx       (cmpl_idx),
        .req_cnt    (req_cnt),
        .retire     (retire),
        .busy       (ack_busy)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        bdt_slot #(.AW(AW), .SW(SW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (enq_ok && (issue_idx == i[0])),
            .wr_addr (enq_addr),
            .wr_len  (len_val),
            .clr     (retire && (cmpl_idx == i[0])),
            .hw_done (dma_done[i]),
            .hw_err  (dma_err[i]),
            .rdy_f   (slot_rdy[i]),
            .done_f  (slot_done[i]),
            .err_f   (slot_err[i]),
            .addr_q  (slot_addr[i*AW +: AW]),
            .len_q   (slot_len[i*SW +: SW])
        );
    end

endmodule

// File: rtl/bdt_checker.sv
module bdt_checker #(
    parameter int CW  = 8,
    parameter int DCW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enq_valid,
    input logic           svc_step,
    input logic           det_valid,
    input logic [DCW-1:0] det_num,
    input logic [1:0]     level,
    input logic           issue_idx,
    input logic           cmpl_idx,
    input logic [CW-1:0]  req_cnt,
    input logic [CW-1:0]  svc_cnt,
    input logic [DCW-1:0] done_cnt,
    input logic           ovf_err,
    input logic           det_err
);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= 2'd2);

    a_r3_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && level == 2'd2 && !svc_step) |=> (ovf_err && level == 2'd2));

    a_r2_issue_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && level < 2'd2) |=> (issue_idx != $past(issue_idx)));

    a_r5_retire_moves_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cnt != $past(req_cnt)) |-> (cmpl_idx != $past(cmpl_idx)));

    a_r6_idle_service: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_step && req_cnt == svc_cnt) |=> (svc_cnt == $past(svc_cnt)));

    a_r8_detach_excess: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && det_num > done_cnt) |=> det_err);

endmodule

bind pingpong_bd_tracker bdt_checker #(.CW(CW), .DCW(DCW)) u_bdt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .svc_step  (svc_step),
    .det_valid (det_valid),
    .det_num   (det_num),
    .level     (level),
    .issue_idx (issue_idx),
    .cmpl_idx  (cmpl_idx),
    .req_cnt   (req_cnt),
    .svc_cnt   (svc_cnt),
    .done_cnt  (done_cnt),
    .ovf_err   (ovf_err),
    .det_err   (det_err)
);

// File: tb/test_pingpong_bd_tracker.sv
`timescale 1ns/1ps
module test_pingpong_bd_tracker;

    localparam int AW = 32, SW = 16, CW = 8, DCW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enq_valid = 0, ack_start = 0, svc_step = 0, det_valid = 0;
    logic [AW-1:0] enq_addr = '0;
    logic [SW-1:0] enq_size = '0;
    logic [1:0] dma_done = '0, dma_err = '0;
    logic [DCW-1:0] det_num = '0;
    logic [1:0] slot_rdy, slot_done, slot_err, level;
    logic [2*AW-1:0] slot_addr;
    logic [2*SW-1:0] slot_len;
    logic issue_idx, cmpl_idx, ready, ack_busy, ovf_err, unf_err, det_err;
    logic [CW-1:0] req_cnt, svc_cnt;
    logic [DCW-1:0] done_cnt;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pingpong_bd_tracker #(.AW(AW), .SW(SW), .CW(CW), .DCW(DCW)) i_pingpong_bd_tracker (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_addr(enq_addr),
        .enq_size(enq_size), .dma_done(dma_done), .dma_err(dma_err),
        .ack_start(ack_start), .svc_step(svc_step), .det_valid(det_valid),
        .det_num(det_num), .slot_rdy(slot_rdy), .slot_done(slot_done),
        .slot_err(slot_err), .slot_addr(slot_addr), .slot_len(slot_len),
        .issue_idx(issue_idx), .cmpl_idx(cmpl_idx), .level(level),
        .req_cnt(req_cnt), .svc_cnt(svc_cnt), .done_cnt(done_cnt),
        .ready(ready), .ack_busy(ack_busy), .ovf_err(ovf_err),
        .unf_err(unf_err), .det_err(det_err)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Apply strobes for one clock edge, then sample just after it.
    task automatic cycle();
        @(posedge clk); #1;
        enq_valid = 0; ack_start = 0; svc_step = 0; det_valid = 0;
        dma_done = '0; dma_err = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic enq(input logic [AW-1:0] a, input logic [SW-1:0] s);
        @(negedge clk); enq_valid = 1; enq_addr = a; enq_size = s; cycle();
    endtask

    task automatic svc();
        @(negedge clk); svc_step = 1; cycle();
    endtask

    task automatic run_ack();
        @(negedge clk); ack_start = 1; cycle();
        for (int k = 0; k < 20 && ack_busy; k++) begin
            @(posedge clk); #1;
        end
        chk("R5 pass ends", ack_busy, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 level", level, 0);       chk("R1 issue", issue_idx, 0);
        chk("R1 cmpl", cmpl_idx, 0);     chk("R1 req", req_cnt, 0);
        chk("R1 svc", svc_cnt, 0);       chk("R1 done", done_cnt, 0);
        chk("R1 rdy", slot_rdy, 0);      chk("R1 flags", {slot_done, slot_err}, 0);
        chk("R9 ready at reset", ready, 1);
    endtask

    task automatic t_enqueue();
        enq(32'hA000_0040, 16'd64);
        chk("R2 slot0 rdy", slot_rdy, 2'b01);
        chk("R2 slot0 addr", slot_addr[31:0], 32'hA000_0040);
        chk("R2 slot0 len", slot_len[15:0], 63);
        chk("R2 issue", issue_idx, 1);   chk("R2 level", level, 1);
        enq(32'hB000_0010, 16'd16);
        chk("R2 slot1 addr", slot_addr[63:32], 32'hB000_0010);
        chk("R2 slot1 len", slot_len[31:16], 15);
        chk("R2 issue back", issue_idx, 0);
        chk("R9 not ready at 2", ready, 0);
        enq(32'hC000_0000, 16'd8);
        chk("R3 ovf pulse", ovf_err, 1);  chk("R3 level", level, 2);
        chk("R3 slot0 kept", slot_addr[31:0], 32'hA000_0040);
        chk("R3 issue kept", issue_idx, 0);
    endtask

    task automatic t_ack_both();
        @(negedge clk); dma_err = 2'b01; cycle();
        chk("R10 err flag", slot_err, 2'b01);
        @(negedge clk); dma_done = 2'b11; cycle();
        chk("R4 done flags", slot_done, 2'b11);
        run_ack();
        chk("R5 req two", req_cnt, 2);   chk("R5 cmpl", cmpl_idx, 0);
        chk("R5 rdy cleared", slot_rdy, 0);
        chk("R5 done cleared", slot_done, 0);
        chk("R10 err cleared", slot_err, 0);
    endtask

    task automatic t_service();
        svc();
        chk("R6 svc", svc_cnt, 1); chk("R6 level", level, 1); chk("R6 done", done_cnt, 1);
        chk("R9 ready again", ready, 1);
        svc();
        chk("R6 done2", done_cnt, 2); chk("R6 level0", level, 0);
        svc();
        chk("R6 idle svc", svc_cnt, 2); chk("R6 idle done", done_cnt, 2);
    endtask

    task automatic t_detach();
        @(negedge clk); det_valid = 1; det_num = 3; cycle();
        chk("R8 det_err", det_err, 1); chk("R8 kept", done_cnt, 2);
        @(negedge clk); det_valid = 1; det_num = 2; cycle();
        chk("R8 no err", det_err, 0); chk("R8 subtract", done_cnt, 0);
    endtask

    task automatic t_order();
        enq(32'h1111_0000, 16'd4);
        enq(32'h2222_0000, 16'd4);
        @(negedge clk); dma_done = 2'b10; cycle();
        run_ack();
        chk("R5 no skip req", req_cnt, 2);
        chk("R5 slot1 still done", slot_done, 2'b10);
        @(negedge clk); dma_done = 2'b01; cycle();
        run_ack();
        chk("R5 in order req", req_cnt, 4); chk("R5 cmpl wrap", cmpl_idx, 0);
    endtask

    task automatic t_concurrent();
        svc();
        chk("R6 level1", level, 1);
        @(negedge clk); svc_step = 1; enq_valid = 1; enq_addr = 32'h3333_0000; enq_size = 16'd2; cycle();
        chk("R11 level same", level, 1); chk("R11 svc", svc_cnt, 4);
        chk("R11 done", done_cnt, 2);    chk("R11 slot0 rdy", slot_rdy, 2'b01);
    endtask

    task automatic t_underflow();
        do_reset();
        @(negedge clk); dma_done = 2'b01; cycle();
        chk("R4 done on idle slot", slot_done, 2'b01);
        run_ack();
        chk("R7 req", req_cnt, 1);
        svc();
        chk("R7 unf pulse", unf_err, 1); chk("R7 svc", svc_cnt, 1);
        chk("R7 level", level, 0);       chk("R7 done", done_cnt, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_enqueue();
        t_ack_both();
        t_service();
        t_detach();
        t_order();
        t_concurrent();
        t_underflow();
        finish_run();
    end

endmodule